// File: doc/BRIEF.md
# Two-Stage Write-Back Cache Controller

This block is a direct-mapped write-back cache placed between a CPU request channel and a memory channel. The CPU sends loads and stores. Load data comes back on a response port. On the memory side the controller sends two kinds of message on one request channel: fetches (Get) and write-backs of dirty victim lines. It takes fill responses on a separate channel. Each line holds a state (Invalid, Clean or Dirty), a full address and one data word. Line state and address sit in one array and the data words sit in another.

Requests flow through two stages. Stage 1 is the cycle in which a request is accepted. In that cycle the controller reads the state/address array, decides hit or miss, decides on eviction and updates line state and address. Stage 2 is the following cycle, in which the controller reads or writes the data array. That is where load data is returned and where a victim's data is read out for its write-back, just before the new data overwrites it. Stores never stall on a miss: they allocate the line at once. A load miss holds the CPU request and runs an eviction, Get and fill sequence. The held load then hits and completes through the normal path.

Top module: `wb_cache_ctrl`

## Requirements
- R1: After reset every line is Invalid, so the first load to any index produces a Get and no write-back, and no CPU response or memory request is active right after reset.
- R2: A store whose address equals the address of a non-Invalid line overwrites that line's data and makes it Dirty. A later load returns the stored word.
- R3: A load that hits is accepted in the cycle it is presented, and cpu_rsp_valid with the line's data appears in the next cycle.
- R4: A load that misses keeps cpu_req_ready low. The controller then issues a Get (mem_req_wb = 0) whose index is the low IDX_W bits of the requested address and whose address is the requested address. The load produces its CPU response only after the fill.
- R5: A memory response accepted while mem_rsp_ready is high writes its address and data into the line named by mem_rsp_idx and marks it Clean. Evicting a Clean line emits no write-back.
- R6: A load miss on a Dirty line first emits a write-back (mem_req_wb = 1) carrying the victim's address and data, then the Get.
- R7: A store whose address misses on a Dirty line is accepted at once. In the next cycle it emits a write-back of the victim's address and data, and the line then holds the new address and data as Dirty.
- R8: Stores presented in consecutive cycles are accepted in consecutive cycles, even when the second one evicts the line that the first one has just written. In that case the write-back carries the first store's data.
- R9: While a write-back waits with mem_req_ready low, the message stays valid and unchanged, and cpu_req_ready stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req_valid | input | 1 | CPU request valid |
| cpu_req_ready | output | 1 | CPU request accepted this cycle |
| cpu_req_store | input | 1 | 1 = store, 0 = load |
| cpu_req_addr | input | ADDR_W | Request address |
| cpu_req_data | input | DATA_W | Store data |
| cpu_rsp_valid | output | 1 | Load data valid (one-cycle pulse) |
| cpu_rsp_data | output | DATA_W | Load data |
| mem_req_valid | output | 1 | Memory message valid |
| mem_req_ready | input | 1 | Memory takes the message |
| mem_req_wb | output | 1 | 1 = write-back, 0 = Get |
| mem_req_idx | output | IDX_W | Line index of the message |
| mem_req_addr | output | ADDR_W | Line address (victim for write-back, requested for Get) |
| mem_req_data | output | DATA_W | Victim data for write-back |
| mem_rsp_valid | input | 1 | Fill response valid |
| mem_rsp_ready | output | 1 | Controller waits for a fill |
| mem_rsp_idx | input | IDX_W | Line to fill |
| mem_rsp_addr | input | ADDR_W | Address of the fill |
| mem_rsp_data | input | DATA_W | Fill data |

## Verification
Two things can happen in the same cycle: a new store performs its stage-1 lookup, and the previous store performs its stage-2 data write to the same index. The bench provokes this by presenting two stores to one index on back-to-back cycles, with the second one at a different address. It checks that both are accepted one cycle apart and that the write-back produced by the second store carries the first store's data, not the stale word. A scoreboard model predicts every CPU response and every memory message in order. Stalls on the memory channel confirm that the write-back stays frozen and the CPU side stays blocked.

// File: rtl/wb_cache_ctrl.sv
module wb_cache_ctrl #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int IDX_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req_valid,
  output logic              cpu_req_ready,
  input  logic              cpu_req_store,
  input  logic [ADDR_W-1:0] cpu_req_addr,
  input  logic [DATA_W-1:0] cpu_req_data,
  output logic              cpu_rsp_valid,
  output logic [DATA_W-1:0] cpu_rsp_data,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_wb,
  output logic [IDX_W-1:0]  mem_req_idx,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [DATA_W-1:0] mem_req_data,
  input  logic              mem_rsp_valid,
  output logic              mem_rsp_ready,
  input  logic [IDX_W-1:0]  mem_rsp_idx,
  input  logic [ADDR_W-1:0] mem_rsp_addr,
  input  logic [DATA_W-1:0] mem_rsp_data
);

  localparam int ENTRIES = 1 << IDX_W;

  typedef enum logic [1:0] {ST_INV = 2'd0, ST_CLEAN = 2'd1, ST_DIRTY = 2'd2} line_st_e;
  typedef enum logic [1:0] {M_IDLE, M_WB, M_GET, M_WAIT} miss_e;

  line_st_e          st_q   [ENTRIES];
  logic [ADDR_W-1:0] tag_q  [ENTRIES];
  logic [DATA_W-1:0] data_q [ENTRIES];

  miss_e             m_st;
  logic [ADDR_W-1:0] m_addr, m_vaddr;
  logic [IDX_W-1:0]  m_idx;

  logic              s2_valid, s2_store, s2_wb;
  logic [IDX_W-1:0]  s2_idx;
  logic [ADDR_W-1:0] s2_wbaddr;
  logic [DATA_W-1:0] s2_data;

  logic [IDX_W-1:0]  cpu_idx;
  logic              hit, victim_dirty, acc, m_go, s2_stall, s2_send, fill;

  // stage 1: lookup and eviction decision
  assign cpu_idx      = cpu_req_addr[IDX_W-1:0];
  assign hit          = (st_q[cpu_idx] != ST_INV) && (tag_q[cpu_idx] == cpu_req_addr);
  assign victim_dirty = (st_q[cpu_idx] == ST_DIRTY) && !hit;
  assign s2_send      = s2_valid && s2_wb;
  assign s2_stall     = s2_send && !mem_req_ready;
  assign cpu_req_ready = (m_st == M_IDLE) && !s2_stall && (cpu_req_store || hit);
  assign acc          = cpu_req_valid && cpu_req_ready;
  assign m_go         = (m_st == M_IDLE) && cpu_req_valid && !cpu_req_store && !hit && !s2_valid;
  assign m_idx        = m_addr[IDX_W-1:0];
  assign mem_rsp_ready = (m_st == M_WAIT);
  assign fill         = mem_rsp_valid && mem_rsp_ready;

  // stage 2 and memory-side outputs
  assign cpu_rsp_valid = s2_valid && !s2_store;
  assign cpu_rsp_data  = data_q[s2_idx];
  assign mem_req_valid = s2_send || (m_st == M_WB) || (m_st == M_GET);
  assign mem_req_wb    = s2_send || (m_st == M_WB);
  assign mem_req_idx   = s2_send ? s2_idx : m_idx;
  assign mem_req_addr  = s2_send ? s2_wbaddr : ((m_st == M_WB) ? m_vaddr : m_addr);
  assign mem_req_data  = data_q[mem_req_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) st_q[i] <= ST_INV;
    end else if (acc && cpu_req_store) begin
      st_q[cpu_idx] <= ST_DIRTY;
    end else if (m_go) begin
      st_q[cpu_idx] <= ST_INV;
    end else if (fill) begin
      st_q[mem_rsp_idx] <= ST_CLEAN;
    end
  end

  always_ff @(posedge clk) begin
    if (acc && cpu_req_store) tag_q[cpu_idx] <= cpu_req_addr;
    else if (fill)            tag_q[mem_rsp_idx] <= mem_rsp_addr;
    if (s2_valid && s2_store && !s2_stall) data_q[s2_idx] <= s2_data;
    else if (fill)                         data_q[mem_rsp_idx] <= mem_rsp_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s2_valid <= 1'b0;
    end else if (!s2_stall) begin
      s2_valid <= acc;
    end
  end

  always_ff @(posedge clk) begin
    if (acc) begin
      s2_store  <= cpu_req_store;
      s2_wb     <= cpu_req_store && victim_dirty;
      s2_idx    <= cpu_idx;
      s2_wbaddr <= tag_q[cpu_idx];
      s2_data   <= cpu_req_data;
    end
  end

  // load-miss sequencer
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m_st <= M_IDLE;
    end else begin
      case (m_st)
        M_IDLE: if (m_go) m_st <= victim_dirty ? M_WB : M_GET;
        M_WB:   if (mem_req_ready) m_st <= M_GET;
        M_GET:  if (mem_req_ready) m_st <= M_WAIT;
        M_WAIT: if (mem_rsp_valid) m_st <= M_IDLE;
        default: m_st <= M_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (m_go) begin
      m_addr  <= cpu_req_addr;
      m_vaddr <= tag_q[cpu_idx];
    end
  end

  a_r3_rsp_follows_load: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rsp_valid |-> $past(cpu_req_valid && cpu_req_ready && !cpu_req_store));

  a_r2_store_marks_dirty: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req_valid && cpu_req_ready && cpu_req_store) |=> (st_q[$past(cpu_idx)] == ST_DIRTY));

  a_r7_store_evicts_dirty: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req_valid && cpu_req_ready && cpu_req_store && st_q[cpu_idx] == ST_DIRTY
     && tag_q[cpu_idx] != cpu_req_addr) |=> (mem_req_valid && mem_req_wb));

  a_r5_fill_marks_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rsp_valid && mem_rsp_ready) |=> (st_q[$past(mem_rsp_idx)] == ST_CLEAN));

  a_r9_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_wb) && $stable(mem_req_addr) && $stable(mem_req_data)));

  a_r4_get_index: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_wb) |-> (mem_req_idx == mem_req_addr[IDX_W-1:0]));

endmodule

// File: tb/wb_cache_ctrl_tb_top.sv
module wb_cache_ctrl_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cpu_req_valid = 0, cpu_req_store = 0;
  logic [7:0] cpu_req_addr = 0;
  logic [15:0] cpu_req_data = 0;
  logic cpu_req_ready, cpu_rsp_valid;
  logic [15:0] cpu_rsp_data;
  logic mem_req_valid, mem_req_wb, mem_rsp_ready;
  logic mem_req_ready = 1;
  logic [1:0] mem_req_idx;
  logic [7:0] mem_req_addr;
  logic [15:0] mem_req_data;
  logic mem_rsp_valid = 0;
  logic [1:0] mem_rsp_idx = 0;
  logic [7:0] mem_rsp_addr = 0;
  logic [15:0] mem_rsp_data = 0;

  always #2.5 clk = ~clk;

  wb_cache_ctrl dut_i (.*);

  int total = 0, bad = 0, cyc = 0, last_acc = 0;
  bit mem_ready_en = 1, rsp_taken = 0;
  int get_cnt = 0;
  logic [1:0] pend_idx;
  logic [7:0] pend_addr;
  logic [15:0] exp_rsp[$];
  logic [26:0] exp_mem[$];
  logic [1:0]  m_st[4];
  logic [7:0]  m_tag[4];
  logic [15:0] m_dat[4];

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [15:0] memval(input logic [7:0] a);
    return {a, ~a} ^ 16'h5a5a;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory model and scoreboard monitor
  always @(negedge clk) begin
    if (rsp_taken) begin mem_rsp_valid = 0; rsp_taken = 0; end
    if (get_cnt > 0) begin
      get_cnt--;
      if (get_cnt == 0) begin
        mem_rsp_valid = 1; mem_rsp_idx = pend_idx;
        mem_rsp_addr = pend_addr; mem_rsp_data = memval(pend_addr);
      end
    end
    mem_req_ready = mem_ready_en;
    #1;
    if (mem_rsp_valid && mem_rsp_ready) rsp_taken = 1;
    if (cpu_rsp_valid) begin
      if (exp_rsp.size() == 0) check(0, "R4 unexpected cpu response", {16'h0, cpu_rsp_data}, 32'h0);
      else begin
        logic [15:0] e;
        e = exp_rsp.pop_front();
        check(cpu_rsp_data == e, "R3 load data", {16'h0, cpu_rsp_data}, {16'h0, e});
      end
    end
    if (mem_req_valid && mem_req_ready) begin
      logic [26:0] act;
      act = {mem_req_wb, mem_req_idx, mem_req_addr, mem_req_wb ? mem_req_data : 16'h0};
      if (exp_mem.size() == 0) check(0, "R6 unexpected memory message", {5'h0, act}, 32'h0);
      else begin
        logic [26:0] e;
        e = exp_mem.pop_front();
        check(act == e, "R6 memory message order/content", {5'h0, act}, {5'h0, e});
      end
      if (!mem_req_wb) begin get_cnt = 2; pend_idx = mem_req_idx; pend_addr = mem_req_addr; end
    end
  end

  // driver: predicts results, then presents the request until accepted
  task automatic cpu_op(input bit st, input logic [7:0] a, input logic [15:0] d, input bit keep);
    logic [1:0] i;
    bit evict_wb, hitp;
    i = a[1:0];
    hitp = (m_st[i] != 0) && (m_tag[i] == a);
    evict_wb = !hitp && (m_st[i] == 2);
    if (evict_wb) exp_mem.push_back({1'b1, i, m_tag[i], m_dat[i]});
    if (st) begin
      m_st[i] = 2; m_tag[i] = a; m_dat[i] = d;
    end else begin
      if (!hitp) begin
        exp_mem.push_back({1'b0, i, a, 16'h0});
        m_st[i] = 1; m_tag[i] = a; m_dat[i] = memval(a);
      end
      exp_rsp.push_back(m_dat[i]);
    end
    cpu_req_valid = 1; cpu_req_store = st; cpu_req_addr = a; cpu_req_data = d;
    forever begin
      #1;
      if (cpu_req_ready) break;
      @(negedge clk);
    end
    last_acc = cyc;
    @(negedge clk);
    if (!keep) begin
      cpu_req_valid = 0;
      #1;
      if (!st) check(cpu_rsp_valid == 1, "R3 response one cycle after accept", cpu_rsp_valid, 1);
      if (st && evict_wb && mem_ready_en)
        check(mem_req_valid && mem_req_wb, "R7 write-back one cycle after store", {mem_req_valid, mem_req_wb}, 2'b11);
      @(negedge clk);
    end
  endtask

  initial begin
    int a1;
    for (int k = 0; k < 4; k++) begin m_st[k] = 0; m_tag[k] = 0; m_dat[k] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    check(!cpu_rsp_valid && !mem_req_valid, "R1 idle after reset", {cpu_rsp_valid, mem_req_valid}, 0);
    @(negedge clk);
    // R1 R4: cold misses on every index issue Get only
    for (int k = 0; k < 4; k++) cpu_op(0, 8'h10 + 8'(k), 0, 0);
    cpu_op(0, 8'h10, 0, 0);                 // R3 hit
    cpu_op(1, 8'h10, 16'h1111, 0);          // R2 store hit
    cpu_op(0, 8'h10, 0, 0);
    cpu_op(0, 8'h20, 0, 0);                 // R6 dirty victim on load miss
    cpu_op(0, 8'h30, 0, 0);                 // R5 clean victim, no write-back
    cpu_op(1, 8'h41, 16'h4141, 0);          // R7 store over clean line
    cpu_op(1, 8'h51, 16'h5151, 0);          // R7 store evicts dirty line
    cpu_op(0, 8'h51, 0, 0);
    // R8 back-to-back stores, second evicts the first
    cpu_op(1, 8'h62, 16'h6262, 1);
    a1 = last_acc;
    cpu_op(1, 8'h72, 16'h7272, 1);
    check(last_acc == a1 + 1, "R8 consecutive acceptance", last_acc, a1 + 1);
    a1 = last_acc;
    cpu_op(1, 8'h03, 16'h0303, 1);
    cpu_op(1, 8'h13, 16'h1313, 1);
    cpu_op(1, 8'h23, 16'h2323, 0);
    check(last_acc == a1 + 3, "R8 three stores in a row", last_acc, a1 + 3);
    // R9 stalled write-back
    mem_ready_en = 0;
    @(negedge clk);
    cpu_op(1, 8'h82, 16'h8282, 1);
    cpu_req_addr = 8'h0B; cpu_req_data = 16'h0B0B;
    for (int k = 0; k < 3; k++) begin
      #1;
      check(mem_req_valid && mem_req_wb && mem_req_addr == 8'h72 && mem_req_data == 16'h7272,
            "R9 write-back held", {mem_req_valid, mem_req_wb, mem_req_addr, mem_req_data}, {2'b11, 8'h72, 16'h7272});
      check(!cpu_req_ready, "R9 cpu blocked", cpu_req_ready, 0);
      @(negedge clk);
    end
    #1 mem_ready_en = 1;
    @(negedge clk);
    cpu_op(1, 8'h0B, 16'h0B0B, 0);
    cpu_op(0, 8'h82, 0, 0);
    cpu_op(0, 8'h0B, 0, 0);
    cpu_op(0, 8'h41, 0, 0);                 // R7 victim reloaded from memory model
    cpu_op(0, 8'h11, 0, 0);
    repeat (8) @(negedge clk);
    check(exp_rsp.size() == 0, "R4 all responses delivered", exp_rsp.size(), 0);
    check(exp_mem.size() == 0, "R6 all memory messages seen", exp_mem.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #50000;
    total++; bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule